// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This controller times one successive-approximation conversion of an on-chip analog-to-digital converter. Software starts a conversion by writing to the result-low register address. Any value may be written, and the value is discarded. On the clock after that write the block raises a busy flag and opens a sampling window. It then runs a fixed number of comparator steps, one per result bit, and in one final cycle copies the finished code into the result register.

Every phase length is a fixed multiple of the input clock, and a prescaler select picks between a fast setting and a slow setting. The slow setting doubles both the sampling window and the step spacing. A new start write always wins over any conversion still under way: that conversion is dropped without trace, and a fresh one begins. The analog capacitor array and the comparator sit outside the block. The block presents a trial code and reads back a single compare bit.

Top module: `adc_timing_seq`

## Requirements
- R1: A high `wr_strobe_i` starts a conversion whatever value `wr_data_i` carries, and that value has no effect on timing or result.
- R2: `busy_o` rises on the cycle after the start strobe and stays high for exactly 48 cycles when `slow_sel_i`=0 (8 sample + 40 convert) or 96 cycles when `slow_sel_i`=1 (16 + 80).
- R3: `sample_en_o` is high for the first 8 (fast) or 16 (slow) busy cycles and low at all other times.
- R4: During the conversion window `step_o` pulses exactly 10 times, one cycle wide, every 4 (fast) or 8 (slow) cycles. The last pulse falls in the last busy cycle. `cmp_i` is sampled at each pulse, starting with the most significant bit.
- R5: `cmp_i`=1 means the analog input is at or above `trial_o`, and the trial bit is then kept; otherwise it is cleared. With an ideal comparator the stored result equals the analog code.
- R6: The write-result phase is the single cycle after the last busy cycle. In that cycle `busy_o` is low, `done_o` is high for that one cycle only, and `result_o` already shows the new code. A start in that cycle leaves the written result in place.
- R7: A start strobe while busy aborts the running conversion. Full timing restarts from the new strobe, no `done_o` appears for the aborted run, and `result_o` keeps its old value.
- R8: A start strobe in the cycle of the final step pulse takes priority, so the result is not written and no `done_o` pulse occurs.
- R9: `slow_sel_i` is captured only with the start strobe, so changing it during a conversion does not change that conversion's timing.
- R10: `result_o` changes only at a write-result phase and otherwise holds its value.
- R11: After reset `busy_o`, `sample_en_o`, `step_o` and `done_o` are low and `result_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; all phase lengths count its periods |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_strobe_i | input | 1 | Bus write to the result-low address; starts or restarts a conversion |
| wr_data_i | input | 8 | Bus write data, ignored |
| slow_sel_i | input | 1 | Prescaler select: 0 fast (8/40), 1 slow (16/80) |
| cmp_i | input | 1 | Comparator decision: 1 when the analog input is at or above `trial_o` |
| busy_o | output | 1 | Conversion in progress (sample and convert phases) |
| sample_en_o | output | 1 | Connects the selected channel to the sampling array |
| step_o | output | 1 | Approximation step strobe; `cmp_i` is sampled with it |
| trial_o | output | 10 | Current trial code presented to the comparator |
| result_o | output | 10 | Last completed conversion result |
| done_o | output | 1 | One-cycle pulse when a result is written |

## Verification
A phase counter that is off by one shows within a single conversion. Either the busy window ends a cycle early or late, or the step pulses drift away from their multiple-of-4 or multiple-of-8 positions, and this is visible cycle by cycle before `done_o`. A wrong bit pointer or keep/clear decision shows as a result that differs from the analog code, and it shows at the very next `done_o`. A broken abort path shows either as a stray `done_o` or as `result_o` moving before the restarted conversion finishes. Both are checked on every cycle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_CONV   = 2'd2,
        PH_WRITE  = 2'd3
    } phase_t;

endpackage

// File: rtl/adc_phase_timer.sv
module adc_phase_timer
    import adc_seq_pkg::*;
#(
    parameter int RES_W       = 10,
    parameter int SAMPLE_BASE = 8,
    parameter int STEP_BASE   = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_i,
    input  logic   slow_i,
    output phase_t phase_o,
    output logic   step_o,
    output logic   last_o
);

    localparam int MAX_LEN = (SAMPLE_BASE > STEP_BASE) ? 2 * SAMPLE_BASE : 2 * STEP_BASE;
    localparam int CNT_W   = $clog2(MAX_LEN);
    localparam int IDX_W   = (RES_W > 1) ? $clog2(RES_W) : 1;

    localparam logic [CNT_W-1:0] SAMP_END_F = CNT_W'(SAMPLE_BASE - 1);
    localparam logic [CNT_W-1:0] SAMP_END_S = CNT_W'(2 * SAMPLE_BASE - 1);
    localparam logic [CNT_W-1:0] STEP_END_F = CNT_W'(STEP_BASE - 1);
    localparam logic [CNT_W-1:0] STEP_END_S = CNT_W'(2 * STEP_BASE - 1);
    localparam logic [IDX_W-1:0] IDX_TOP    = IDX_W'(RES_W - 1);

    typedef struct packed {
        phase_t           phase;
        logic             slow;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
    } timer_t;

    timer_t tm_q, tm_d;
    logic [CNT_W-1:0] samp_end, step_end;
    logic step_hit;

    always_comb begin
        samp_end = tm_q.slow ? SAMP_END_S : SAMP_END_F;
        step_end = tm_q.slow ? STEP_END_S : STEP_END_F;
        step_hit = (tm_q.phase == PH_CONV) && (tm_q.cnt == step_end);
        tm_d     = tm_q;
        if (start_i) begin
            tm_d.phase = PH_SAMPLE;
            tm_d.slow  = slow_i;
            tm_d.cnt   = '0;
            tm_d.idx   = IDX_TOP;
        end else begin
            unique case (tm_q.phase)
                PH_SAMPLE: begin
                    if (tm_q.cnt == samp_end) begin
                        tm_d.phase = PH_CONV;
                        tm_d.cnt   = '0;
                        tm_d.idx   = IDX_TOP;
                    end else begin
                        tm_d.cnt = tm_q.cnt + 1'b1;
                    end
                end
                PH_CONV: begin
                    if (step_hit) begin
                        tm_d.cnt = '0;
                        if (tm_q.idx == '0) tm_d.phase = PH_WRITE;
                        else                tm_d.idx   = tm_q.idx - 1'b1;
                    end else begin
                        tm_d.cnt = tm_q.cnt + 1'b1;
                    end
                end
                PH_WRITE: tm_d.phase = PH_IDLE;
                default:  tm_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q <= '{phase: PH_IDLE, slow: 1'b0, cnt: '0, idx: '0};
        end else begin
            tm_q <= tm_d;
        end
    end

    assign phase_o = tm_q.phase;
    assign step_o  = step_hit;
    assign last_o  = step_hit && (tm_q.idx == '0);

endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             step_i,
    input  logic             last_i,
    input  logic             cmp_i,
    output logic [RES_W-1:0] trial_o,
    output logic [RES_W-1:0] result_o,
    output logic             done_o
);

    localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

    typedef struct packed {
        logic [RES_W-1:0] trial;
        logic [RES_W-1:0] mask;
        logic [RES_W-1:0] result;
        logic             done;
    } sar_t;

    sar_t sr_q, sr_d;
    logic [RES_W-1:0] kept;

    always_comb begin
        kept      = cmp_i ? sr_q.trial : (sr_q.trial & ~sr_q.mask);
        sr_d      = sr_q;
        sr_d.done = 1'b0;
        if (start_i) begin
            sr_d.trial = TOP_BIT;
            sr_d.mask  = TOP_BIT;
        end else if (step_i) begin
            if (last_i) begin
                sr_d.trial  = kept;
                sr_d.result = kept;
                sr_d.done   = 1'b1;
            end else begin
                sr_d.trial = kept | (sr_q.mask >> 1);
                sr_d.mask  = sr_q.mask >> 1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '{trial: '0, mask: '0, result: '0, done: 1'b0};
        end else begin
            sr_q <= sr_d;
        end
    end

    assign trial_o  = sr_q.trial;
    assign result_o = sr_q.result;
    assign done_o   = sr_q.done;

endmodule

// File: rtl/adc_timing_seq.sv
module adc_timing_seq
    import adc_seq_pkg::*;
#(
    parameter int RES_W       = 10,
    parameter int DATA_W      = 8,
    parameter int SAMPLE_BASE = 8,
    parameter int CONV_BASE   = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_strobe_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              slow_sel_i,
    input  logic              cmp_i,
    output logic              busy_o,
    output logic              sample_en_o,
    output logic              step_o,
    output logic [RES_W-1:0]  trial_o,
    output logic [RES_W-1:0]  result_o,
    output logic              done_o
);

    localparam int STEP_BASE = CONV_BASE / RES_W;

    phase_t phase;
    logic   step_stb;
    logic   last_stb;
    logic   data_unused;

    assign data_unused = ^wr_data_i;

    adc_phase_timer #(
        .RES_W       (RES_W),
        .SAMPLE_BASE (SAMPLE_BASE),
        .STEP_BASE   (STEP_BASE)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (wr_strobe_i),
        .slow_i  (slow_sel_i),
        .phase_o (phase),
        .step_o  (step_stb),
        .last_o  (last_stb)
    );

    adc_sar_core #(
        .RES_W (RES_W)
    ) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (wr_strobe_i),
        .step_i   (step_stb),
        .last_i   (last_stb),
        .cmp_i    (cmp_i),
        .trial_o  (trial_o),
        .result_o (result_o),
        .done_o   (done_o)
    );

    assign busy_o      = (phase == PH_SAMPLE) || (phase == PH_CONV);
    assign sample_en_o = (phase == PH_SAMPLE);
    assign step_o      = step_stb;

endmodule

module adc_timing_seq_chk #(
    parameter int RES_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_strobe_i,
    input logic             busy_o,
    input logic             sample_en_o,
    input logic             step_o,
    input logic [RES_W-1:0] result_o,
    input logic             done_o
);

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe_i |=> busy_o); // R2
    AST_SAMPLE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe_i |=> (sample_en_o && !step_o)); // R3
    AST_STEP_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |-> (busy_o && !sample_en_o)); // R4
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R6
    AST_FALL_IS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6
    AST_ABORT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe_i |=> !done_o); // R7
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o)); // R10

endmodule

bind adc_timing_seq adc_timing_seq_chk #(.RES_W(RES_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_strobe_i (wr_strobe_i),
    .busy_o      (busy_o),
    .sample_en_o (sample_en_o),
    .step_o      (step_o),
    .result_o    (result_o),
    .done_o      (done_o)
);

// File: tb/adc_timing_seq_test.sv
module adc_timing_seq_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic [7:0] wr_data;
    logic       psel;
    logic [9:0] analog;
    logic       cmp;
    logic       busy, samp, step, done;
    logic [9:0] trial, result;

    int n_checks = 0;
    int n_fail   = 0;
    logic [9:0] last_res;

    always #5 clk = ~clk;

    assign cmp = (analog >= trial);

    adc_timing_seq uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_strobe_i (start),
        .wr_data_i   (wr_data),
        .slow_sel_i  (psel),
        .cmp_i       (cmp),
        .busy_o      (busy),
        .sample_en_o (samp),
        .step_o      (step),
        .trial_o     (trial),
        .result_o    (result),
        .done_o      (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic launch(input logic [7:0] data, input bit ps, input int a);
        start   = 1'b1;
        wr_data = data;
        psel    = ps;
        analog  = a[9:0];
        @(negedge clk);
        start = 1'b0;
        psel  = ~ps;     // R9: change mid-conversion must have no effect
    endtask

    // Observes one conversion from cycle 1 (the negedge after the start edge).
    task automatic watch(input bit ps, input int a, input int abort_at, input string tag);
        int s_len = ps ? 16 : 8;
        int c_len = ps ? 80 : 40;
        int st    = c_len / 10;
        int be = 0, se = 0, te = 0, de = 0, he = 0;
        for (int n = 1; n <= s_len + c_len + 2; n++) begin
            bit eb, es, et, ed;
            if (n > 1) @(negedge clk);
            eb = (n <= s_len + c_len);
            es = (n <= s_len);
            et = (n > s_len) && (n <= s_len + c_len) && (((n - s_len) % st) == 0);
            ed = (n == s_len + c_len + 1);
            if (busy !== eb) be++;
            if (samp !== es) se++;
            if (step !== et) te++;
            if (done !== ed) de++;
            if (done === 1'b1) begin
                check(result == a[9:0], {tag, " R5 result"}, result, a);
                last_res = result;
            end else if (result !== last_res) begin
                he++;
            end
            if (n == abort_at) break;
        end
        check(be == 0, {tag, " R2 busy window"}, be, 0);
        check(se == 0, {tag, " R3 sample window"}, se, 0);
        check(te == 0, {tag, " R4 step strobes"}, te, 0);
        check(de == 0, {tag, " R6 done pulse"}, de, 0);
        check(he == 0, {tag, " R10 result hold"}, he, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        rst_n   = 1'b0;
        start   = 1'b0;
        wr_data = 8'h00;
        psel    = 1'b0;
        analog  = 10'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(busy === 1'b0, "R11 busy", busy, 0);
        check(samp === 1'b0, "R11 sample_en", samp, 0);
        check(step === 1'b0, "R11 step", step, 0);
        check(done === 1'b0, "R11 done", done, 0);
        check(result === 10'd0, "R11 result", result, 0);
        last_res = 10'd0;

        // Sweep both prescaler settings over many analog codes (R1 data varies)
        for (int ps = 0; ps < 2; ps++) begin
            for (int a = 0; a < 1024; a += 31) begin
                launch(8'(a) ^ 8'h5A, ps[0], a);
                watch(ps[0], a, 0, "sweep");
            end
            launch(8'h00, ps[0], 511);  watch(ps[0], 511, 0, "edge");
            launch(8'hFF, ps[0], 512);  watch(ps[0], 512, 0, "edge");
            launch(8'hA5, ps[0], 1023); watch(ps[0], 1023, 0, "edge");
        end

        // R1: same analog code, opposite data patterns
        launch(8'h00, 1'b0, 300); watch(1'b0, 300, 0, "R1 data=00");
        launch(8'hFF, 1'b0, 300); watch(1'b0, 300, 0, "R1 data=FF");
        check(result == 10'd300, "R1 data ignored", result, 300);

        // R7: restart in mid-conversion, switching prescaler
        launch(8'h11, 1'b0, 100); watch(1'b0, 100, 20, "R7 aborted");
        check(result == 10'd300, "R7 result kept", result, 300);
        launch(8'h22, 1'b1, 700); watch(1'b1, 700, 0, "R7 restarted");

        // R8: restart in the cycle of the final step strobe
        launch(8'h33, 1'b0, 200); watch(1'b0, 200, 48, "R8 aborted");
        check(step === 1'b1, "R8 restart on last step", step, 1);
        launch(8'h44, 1'b0, 333); watch(1'b0, 333, 0, "R8 restarted");
        check(result == 10'd333, "R8 no stale write", result, 333);

        // R6: restart in the write-result cycle keeps the written code
        launch(8'h55, 1'b1, 900); watch(1'b1, 900, 97, "R6 write cycle");
        launch(8'h66, 1'b0, 50);
        check(result == 10'd900, "R6 result kept after start", result, 900);
        watch(1'b0, 50, 0, "R6 following");

        summary();
        $finish;
    end

endmodule